// File: doc/BRIEF.md
# Countdown Timer With Interrupt Flags

This block is a programmable down-counter paired with an interrupt control register. A host reaches it through a plain register bus: address, write data, write strobe, read strobe and read data. While the run bit is set, each pulse on the tick input moves the counter one step toward zero. When the counter runs out, a sticky timer flag is raised. The counter then either halts or reloads its preset and carries on, depending on a mode bit.

An external alarm-match pulse raises a separate sticky alarm flag. Each flag has its own enable. The two gated flags are ORed onto one active-low interrupt line. Software reads the control register to find out which source fired, and clears a flag by writing 0 to its bit.

Register map (8-bit data):

| Address | Content |
|---|---|
| 0x01 | Control register |
| 0x02 | Run register; bit 0 is the run enable, every other bit reads 0 |
| 0x03 | Preset value; reads back the stored preset |
| 0x04 | Live count, read-only |

Any other address reads 0.

Top module: `cdt_irq_timer`

## Requirements
- R1: After reset, the control register, the run register and the count all read 0, and `irq_n` is 1.
- R2: The control register at address 0x01 has these bits: bit 4 selects the mode (1 = reload, 0 = one-shot), bit 3 is the alarm flag, bit 2 is the timer flag, bit 1 is the alarm interrupt enable and bit 0 is the timer interrupt enable. Bits 7 to 5 read as 0 and ignore writes.
- R3: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged, so a write can never set a flag.
- R4: In one-shot mode with run set, each tick lowers the count by one. The tick that finds the count at 1 (or at 0) sets the timer flag, leaves the count at 0 and halts the counter. Later ticks change nothing.
- R5: In reload mode, the tick that finds the count at 1 (or at 0) sets the timer flag and loads the preset into the counter, which keeps counting.
- R6: A pulse on `alarm_hit` sets the alarm flag on the next clock edge.
- R7: If a flag-setting event and a write that clears that flag arrive in the same cycle, the flag ends up set.
- R8: `irq_n` is 0 exactly when (alarm enable and alarm flag) or (timer enable and timer flag) is true.
- R9: With both enables at 0, `irq_n` stays 1 while both flags still set and can be read back.
- R10: A write to the preset while the counter is stopped loads the counter with that value and clears a one-shot halt. The counter is stopped when run is 0 or the one-shot has halted. A preset write while the counter is running leaves the count alone and only takes effect at the next reload.
- R11: With run at 0, ticks do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_rdata | output | 8 | Read data (combinational) |
| tick | input | 1 | Count pulse, one clock wide |
| alarm_hit | input | 1 | Alarm match pulse |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
The bench targets four corner cases:
- **Expiry tick racing a flag-clearing write.** A design that lets the clear win would lose an interrupt.
- **All ones written to the control register.** A design that treats flag bits as plain storage would raise flags from software, and one that stores bits 7 to 5 would read them back.
- **Preset written while the counter runs.** A design that reloads on every preset write would restart the period mid-count.
- **Behaviour after a one-shot expiry.** A design that keeps counting would wrap to the top value, and one that never halts would set the flag again.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned CDT_DW = 8;

  // register addresses
  localparam logic [7:0] CDT_A_CTRL   = 8'h01;
  localparam logic [7:0] CDT_A_RUN    = 8'h02;
  localparam logic [7:0] CDT_A_PRESET = 8'h03;
  localparam logic [7:0] CDT_A_COUNT  = 8'h04;

  // control register bit positions
  localparam int unsigned CB_MODE = 4;
  localparam int unsigned CB_AF   = 3;
  localparam int unsigned CB_TF   = 2;
  localparam int unsigned CB_AIE  = 1;
  localparam int unsigned CB_TIE  = 0;

  typedef struct packed {
    logic mode;
    logic af;
    logic tf;
    logic aie;
    logic tie;
  } cdt_ctrl_t;

  function automatic logic [7:0] cdt_pack_ctrl(cdt_ctrl_t c);
    logic [7:0] r;
    r = '0;
    r[CB_MODE] = c.mode;
    r[CB_AF]   = c.af;
    r[CB_TF]   = c.tf;
    r[CB_AIE]  = c.aie;
    r[CB_TIE]  = c.tie;
    return r;
  endfunction
endpackage

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg
  import cdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  input  logic       alarm_evt,
  input  logic       timer_evt,
  output cdt_ctrl_t  ctrl_o
);
  cdt_ctrl_t ctrl_q;

  // a set event outranks a software clear; writing 1 never sets a flag
  function automatic logic flag_next(logic cur, logic evt, logic wr, logic wbit);
    if (evt) return 1'b1;
    if (wr && !wbit) return 1'b0;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q.af <= flag_next(ctrl_q.af, alarm_evt, wr_ctrl, wdata[CB_AF]);
      ctrl_q.tf <= flag_next(ctrl_q.tf, timer_evt, wr_ctrl, wdata[CB_TF]);
      if (wr_ctrl) begin
        ctrl_q.mode <= wdata[CB_MODE];
        ctrl_q.aie  <= wdata[CB_AIE];
        ctrl_q.tie  <= wdata[CB_TIE];
      end
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             reload_mode,
  input  logic             preset_wr,
  input  logic [CNT_W-1:0] preset_din,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] preset_o,
  output logic             expire_o,
  output logic             running_o
);
  logic [CNT_W-1:0] count_q, preset_q;
  logic             halted_q;

  // next count on an active tick
  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] cur,
                                                  logic [CNT_W-1:0] pre,
                                                  logic mode);
    if (cur <= CNT_W'(1)) return mode ? pre : '0;
    return cur - CNT_W'(1);
  endfunction

  assign running_o = run && !halted_q;
  assign expire_o  = tick && running_o && (count_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      preset_q <= '0;
      halted_q <= 1'b0;
    end else begin
      if (preset_wr) preset_q <= preset_din;
      if (preset_wr && !running_o) begin
        count_q  <= preset_din;
        halted_q <= 1'b0;
      end else if (tick && running_o) begin
        count_q <= step_count(count_q, preset_q, reload_mode);
        if (expire_o && !reload_mode) halted_q <= 1'b1;
      end
    end
  end

  assign count_o  = count_q;
  assign preset_o = preset_q;
endmodule

// File: rtl/cdt_irq_combine.sv
module cdt_irq_combine #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] enables,
  output logic            irq_n
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign gated[i] = flags[i] & enables[i];
  end

  assign irq_n = ~(|gated);
endmodule

// File: rtl/cdt_irq_timer.sv
module cdt_irq_timer
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              tick,
  input  logic              alarm_hit,
  output logic              irq_n
);
  localparam int unsigned DW = CDT_DW;

  cdt_ctrl_t     ctrl;
  logic          run_q;
  logic [DW-1:0] count, preset;
  logic          tmr_evt, running;
  logic          sel_ctrl, sel_run, sel_preset, sel_count;

  assign sel_ctrl   = (8'(bus_addr) == CDT_A_CTRL);
  assign sel_run    = (8'(bus_addr) == CDT_A_RUN);
  assign sel_preset = (8'(bus_addr) == CDT_A_PRESET);
  assign sel_count  = (8'(bus_addr) == CDT_A_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else if (bus_wr && sel_run) run_q <= bus_wdata[0];
  end

  cdt_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (bus_wr && sel_ctrl),
    .wdata     (bus_wdata),
    .alarm_evt (alarm_hit),
    .timer_evt (tmr_evt),
    .ctrl_o    (ctrl)
  );

  cdt_down_counter #(.CNT_W(DW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .run         (run_q),
    .reload_mode (ctrl.mode),
    .preset_wr   (bus_wr && sel_preset),
    .preset_din  (bus_wdata),
    .count_o     (count),
    .preset_o    (preset),
    .expire_o    (tmr_evt),
    .running_o   (running)
  );

  cdt_irq_combine #(.NSRC(2)) u_irq (
    .flags   ({ctrl.af,  ctrl.tf}),
    .enables ({ctrl.aie, ctrl.tie}),
    .irq_n   (irq_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ctrl)        bus_rdata = cdt_pack_ctrl(ctrl);
      else if (sel_run)    bus_rdata = {7'b0, run_q};
      else if (sel_preset) bus_rdata = preset;
      else if (sel_count)  bus_rdata = count;
    end
  end
endmodule

// File: rtl/cdt_irq_timer_chk.sv
module cdt_irq_timer_chk
  import cdt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       irq_n,
  input logic       alarm_hit,
  input logic       tmr_evt,
  input logic       tick,
  input logic       running,
  input logic       run_q,
  input logic       preset_wr,
  input cdt_ctrl_t  ctrl,
  input logic [7:0] count,
  input logic [7:0] preset
);
  // R6
  alarm_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> ctrl.af);
  // R7
  timer_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> ctrl.tf);
  // R4
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_evt && !ctrl.mode && !preset_wr) |=> (count == 8'd0 && !running));
  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_evt && ctrl.mode && !preset_wr) |=> (count == $past(preset)));
  // R11
  idle_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !preset_wr) |=> $stable(count));
  // R8
  timer_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.tie && ctrl.tf) |-> !irq_n);
  // R8
  alarm_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.aie && ctrl.af) |-> !irq_n);
  // R9
  masked_irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.aie && !ctrl.tie) |-> irq_n);
  // R3
  flag_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.tf && !tmr_evt) |=> !ctrl.tf);
endmodule

bind cdt_irq_timer cdt_irq_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_n     (irq_n),
  .alarm_hit (alarm_hit),
  .tmr_evt   (tmr_evt),
  .tick      (tick),
  .running   (running),
  .run_q     (run_q),
  .preset_wr (bus_wr && sel_preset),
  .ctrl      (ctrl),
  .count     (count),
  .preset    (preset)
);

// File: tb/cdt_irq_timer_tb_top.sv
`timescale 1ns/1ps
module cdt_irq_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, tick = 1'b0, alarm_hit = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_n;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  cdt_irq_timer #(.ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick(tick), .alarm_hit(alarm_hit), .irq_n(irq_n)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk(4'h1, 8'h00, "R1 ctrl");
    rd_chk(4'h2, 8'h00, "R1 run");
    rd_chk(4'h4, 8'h00, "R1 count");
    check("R1 irq_n", 8'(irq_n), 8'h01);
  endtask

  task automatic t_oneshot();
    wr(4'h3, 8'd3);
    rd_chk(4'h4, 8'd3, "R10 stopped preset load");
    pulse_tick();
    rd_chk(4'h4, 8'd3, "R11 tick ignored while run=0");
    wr(4'h2, 8'h01);
    pulse_tick(); rd_chk(4'h4, 8'd2, "R4 step 1");
    pulse_tick(); rd_chk(4'h4, 8'd1, "R4 step 2");
    rd_chk(4'h1, 8'h00, "R4 no flag yet");
    pulse_tick(); rd_chk(4'h4, 8'd0, "R4 expiry count");
    rd_chk(4'h1, 8'h04, "R4 timer flag");
    check("R9 irq masked", 8'(irq_n), 8'h01);
    pulse_tick(); rd_chk(4'h4, 8'd0, "R4 halted stays 0");
  endtask

  task automatic t_ctrl_bits();
    wr(4'h1, 8'hFF);
    rd_chk(4'h1, 8'h17, "R2 upper bits ignored, R3 af not set");
    check("R8 irq on tf&tie", 8'(irq_n), 8'h00);
    wr(4'h1, 8'h13);
    rd_chk(4'h1, 8'h13, "R3 tf cleared");
    check("R8 irq released", 8'(irq_n), 8'h01);
  endtask

  task automatic t_reload();
    wr(4'h3, 8'd2);
    rd_chk(4'h4, 8'd2, "R10 reload after halt");
    pulse_tick(); rd_chk(4'h4, 8'd1, "R5 step");
    pulse_tick(); rd_chk(4'h4, 8'd2, "R5 reload value");
    rd_chk(4'h1, 8'h17, "R5 timer flag");
    check("R8 irq low", 8'(irq_n), 8'h00);
    wr(4'h3, 8'd5);
    rd_chk(4'h4, 8'd2, "R10 running preset write keeps count");
    pulse_tick(); rd_chk(4'h4, 8'd1, "R5 step");
    pulse_tick(); rd_chk(4'h4, 8'd5, "R5 new preset at reload");
  endtask

  task automatic t_alarm();
    wr(4'h1, 8'h13);
    @(negedge clk); alarm_hit = 1'b1;
    @(negedge clk); alarm_hit = 1'b0;
    rd_chk(4'h1, 8'h1B, "R6 alarm flag");
    check("R8 alarm irq", 8'(irq_n), 8'h00);
    wr(4'h1, 8'h18);
    rd_chk(4'h1, 8'h18, "R9 flag kept with enables off");
    check("R9 irq high", 8'(irq_n), 8'h01);
  endtask

  task automatic t_race();
    @(negedge clk);
    bus_addr = 4'h1; bus_wdata = 8'h10; bus_wr = 1'b1; alarm_hit = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; alarm_hit = 1'b0;
    rd_chk(4'h1, 8'h18, "R7 alarm beats clear");
    for (int i = 0; i < 4; i++) pulse_tick();
    rd_chk(4'h4, 8'd1, "R5 count before race");
    @(negedge clk);
    bus_addr = 4'h1; bus_wdata = 8'h10; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    rd_chk(4'h1, 8'h14, "R7 timer beats clear, af cleared");
    rd_chk(4'h4, 8'd5, "R5 reload in race");
  endtask

  task automatic t_stop();
    wr(4'h2, 8'hFF);
    rd_chk(4'h2, 8'h01, "R11 run reg upper bits 0");
    wr(4'h2, 8'h00);
    pulse_tick();
    rd_chk(4'h4, 8'd5, "R11 stopped count");
    wr(4'h3, 8'd7);
    rd_chk(4'h4, 8'd7, "R10 stopped load");
    rd_chk(4'h3, 8'd7, "R10 preset readback");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_oneshot();
    t_ctrl_bits();
    t_reload();
    t_alarm();
    t_race();
    t_stop();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule